// File: doc/BRIEF.md
# Card Socket Status and Change-Interrupt Unit

This block holds the per-socket control and status registers of a removable-card socket controller. A host reaches them through one byte-wide indexed register port. The index byte carries three fields: a controller-half bit, a socket bit and a 6-bit register offset. Each socket therefore owns a private block of 64 offsets, and seven of them are implemented.

Each socket has seven sense pins: two card-detect, two battery-voltage-detect, write-protect, ready and power-good. They pass through a two-flop synchronizer and are shown in a status register. A card counts as present only when both detect pins are high.

Changes in presence and falling battery-detect levels are latched in a per-socket change register. The host reads that register to take the latched bits, and the read also clears them. Each socket routes its enabled change bits to a programmable management IRQ line.

The same register set drives the socket's power-enable, output-enable, programming-voltage select, card-reset and I/O-mode outputs.

Top module: `sock_stat_unit`

## Requirements
- R1: Offset 0x00 reads the identification byte `ID_CODE` (default 0x83; upper nibble 0x8, revision 0x2 to 0x4). Writes to it have no effect.
- R2: Offset 0x01 reads the synchronized pins, two clocks after the pin change: bit 0 battery-detect A, bit 1 battery-detect B, bit 2 detect A, bit 3 detect B, bit 4 write-protect, bit 5 ready, bit 6 power-good, bit 7 zero.
- R3: Offset 0x02 (power control) stores bits 7, 5, 4, 1 and 0, and the other bits read 0.
  - `pwr_en_o` = bit 4 AND (bit 5 clear OR card present).
  - `out_en_o` = bit 7 AND `pwr_en_o`.
  - `vpp_sel_o` = bits 1:0 (1 = 5 V, 2 = 12 V, 0 = off).
  - Writing 0x00 drives `pwr_en_o` and `out_en_o` low at the write's clock edge.
- R4: Offset 0x03 (general control) stores bits 6:0, and bit 7 reads 0. `card_rst_n_o` follows bit 6, so a clear bit holds the card in reset. `io_mode_o` follows bit 5. Bits 3:0 hold the card's routed IRQ number.
- R5: Offset 0x04 (change register) latches these events:
  - bit 3 when card presence (detect A AND detect B) toggles;
  - bit 1 when battery-detect B falls;
  - bit 0 when battery-detect A falls.
  Rising battery levels set nothing, and host writes to this offset are ignored.
- R6: A read of offset 0x04 returns the latched bits and clears them at the same clock edge. An event detected at that same edge is kept and appears in the next read.
- R7: Offset 0x05 (interrupt config) is fully read/write. Bits 3, 1 and 0 enable change bits 3, 1 and 0 respectively. A socket is pending when any enabled change bit is set. The socket then drives `irq_lines_o[bits 7:4]` high, and `irq_any_o` is the OR of all sockets' pending flags.
- R8: Index bit 7 selects the controller half and bit 6 selects the socket, so sockets are fully independent. When bit 7 addresses a half beyond `NUM_CTRL`, reads return 0x00 and writes are ignored.
- R9: Offset 0x06 is an 8-bit read/write window-enable register. All other offsets read 0x00.
- R10: After reset:
  - every writable register is 0x00;
  - `pwr_en_o`, `out_en_o`, `card_rst_n_o` and `irq_any_o` are low;
  - `irq_lines_o` is 0.
- R11: Read data appears on `reg_rdata` one clock after the edge that samples `reg_rd`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 8 | Register index: bit 7 controller half, bit 6 socket, bits 5:0 offset |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe for one clock |
| reg_rdata | output | 8 | Registered read data |
| det_a_i | input | NS | Card-detect pin A per socket |
| det_b_i | input | NS | Card-detect pin B per socket |
| batt_a_i | input | NS | Battery-detect pin A per socket |
| batt_b_i | input | NS | Battery-detect pin B per socket |
| wprot_i | input | NS | Write-protect pin per socket |
| ready_i | input | NS | Ready pin per socket |
| pgood_i | input | NS | Power-good pin per socket |
| pwr_en_o | output | NS | Socket power enable |
| out_en_o | output | NS | Socket output enable |
| vpp_sel_o | output | 2*NS | Programming-voltage code per socket |
| card_rst_n_o | output | NS | Active-low card reset |
| io_mode_o | output | NS | I/O-card mode select |
| irq_lines_o | output | 16 | Management IRQ lines |
| irq_any_o | output | 1 | Any socket pending |

## Verification
The bench builds the unit with `NUM_CTRL` = 1, which gives two sockets. Index bit 7 then addresses a controller half that does not exist, so the unmapped-index decode of R8 becomes observable alongside the isolation of the two sockets. Pin changes are timed against the host's read of the change register so that a new event lands on the clearing edge. Each socket is also routed to a different IRQ number to show that the routing is independent per socket.

// File: rtl/sockstat_pkg.sv
package sockstat_pkg;
  localparam logic [5:0] OFF_ID   = 6'h00;
  localparam logic [5:0] OFF_STAT = 6'h01;
  localparam logic [5:0] OFF_PWR  = 6'h02;
  localparam logic [5:0] OFF_CTL  = 6'h03;
  localparam logic [5:0] OFF_CHG  = 6'h04;
  localparam logic [5:0] OFF_CFG  = 6'h05;
  localparam logic [5:0] OFF_WIN  = 6'h06;

  localparam int PIN_W = 7;
  localparam int IRQ_N = 16;

  // field order is the status byte layout, bit 6 down to bit 0
  typedef struct packed {
    logic pgood;
    logic ready;
    logic wprot;
    logic det_b;
    logic det_a;
    logic batt_b;
    logic batt_a;
  } pins_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      dout   <= '0;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/sock_regs.sv
module sock_regs
  import sockstat_pkg::*;
#(
  parameter logic [7:0] ID_CODE = 8'h83
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pins_t      pins,
  input  logic       wr,
  input  logic       rd,
  input  logic [5:0] off,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       pwr_en,
  output logic       out_en,
  output logic [1:0] vpp,
  output logic       card_rst_n,
  output logic       io_mode,
  output logic       pend,
  output logic [3:0] irq_num
);
  localparam logic [7:0] PWR_MASK = 8'hB3;

  logic [7:0] pwr_q;
  logic [6:0] ctl_q;
  logic [2:0] chg_q;   // {detect, batt warn, batt dead}
  logic [7:0] cfg_q;
  logic [7:0] win_q;
  logic       pres_q, bb_q, ba_q;
  logic       present, evt_det, evt_warn, evt_dead;
  logic       rd_chg;

  assign present  = pins.det_a & pins.det_b;
  assign evt_det  = present ^ pres_q;
  assign evt_warn = bb_q & ~pins.batt_b;
  assign evt_dead = ba_q & ~pins.batt_a;
  assign rd_chg   = rd && (off == OFF_CHG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= '0;
      ctl_q  <= '0;
      chg_q  <= '0;
      cfg_q  <= '0;
      win_q  <= '0;
      pres_q <= 1'b0;
      bb_q   <= 1'b0;
      ba_q   <= 1'b0;
    end else begin
      pres_q <= present;
      bb_q   <= pins.batt_b;
      ba_q   <= pins.batt_a;
      chg_q  <= (rd_chg ? 3'b000 : chg_q) | {evt_det, evt_warn, evt_dead};
      if (wr) begin
        case (off)
          OFF_PWR: pwr_q <= wdata & PWR_MASK;
          OFF_CTL: ctl_q <= wdata[6:0];
          OFF_CFG: cfg_q <= wdata;
          OFF_WIN: win_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      OFF_ID:   rdata = ID_CODE;
      OFF_STAT: rdata = {1'b0, pins};
      OFF_PWR:  rdata = pwr_q;
      OFF_CTL:  rdata = {1'b0, ctl_q};
      OFF_CHG:  rdata = {4'b0000, chg_q[2], 1'b0, chg_q[1:0]};
      OFF_CFG:  rdata = cfg_q;
      OFF_WIN:  rdata = win_q;
      default:  rdata = 8'h00;
    endcase
  end

  assign pwr_en     = pwr_q[4] & (~pwr_q[5] | present);
  assign out_en     = pwr_q[7] & pwr_en;
  assign vpp        = pwr_q[1:0];
  assign card_rst_n = ctl_q[6];
  assign io_mode    = ctl_q[5];
  assign pend       = |(chg_q & {cfg_q[3], cfg_q[1], cfg_q[0]});
  assign irq_num    = cfg_q[7:4];

  assert_pwr_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_PWR && wdata == 8'h00) |=> (!pwr_en && !out_en));
  assert_rst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_CTL && !wdata[6]) |=> !card_rst_n);
  assert_chg_nowr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd && !evt_det && !evt_warn && !evt_dead) |=> $stable(chg_q));
  assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chg && !evt_det && !evt_warn && !evt_dead) |=> (chg_q == 3'b000));
  assert_keep_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_det |=> chg_q[2]);
endmodule

// File: rtl/irq_router.sv
module irq_router
  import sockstat_pkg::*;
#(
  parameter int NS = 4
) (
  input  logic [NS-1:0]   pend,
  input  logic [4*NS-1:0] num,
  output logic [IRQ_N-1:0] lines,
  output logic             any
);
  always_comb begin
    lines = '0;
    for (int s = 0; s < NS; s++) begin
      if (pend[s]) lines[num[4*s +: 4]] = 1'b1;
    end
  end
  assign any = |pend;
endmodule

// File: rtl/sock_stat_unit.sv
module sock_stat_unit
  import sockstat_pkg::*;
#(
  parameter int         NUM_CTRL = 2,
  parameter logic [7:0] ID_CODE  = 8'h83,
  localparam int        NS       = NUM_CTRL * 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    reg_idx,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_rd,
  output logic [7:0]    reg_rdata,
  input  logic [NS-1:0] det_a_i,
  input  logic [NS-1:0] det_b_i,
  input  logic [NS-1:0] batt_a_i,
  input  logic [NS-1:0] batt_b_i,
  input  logic [NS-1:0] wprot_i,
  input  logic [NS-1:0] ready_i,
  input  logic [NS-1:0] pgood_i,
  output logic [NS-1:0] pwr_en_o,
  output logic [NS-1:0] out_en_o,
  output logic [2*NS-1:0] vpp_sel_o,
  output logic [NS-1:0] card_rst_n_o,
  output logic [NS-1:0] io_mode_o,
  output logic [15:0]   irq_lines_o,
  output logic          irq_any_o
);
  localparam int SYNC_W = PIN_W * NS;

  logic [1:0]        sel;
  logic              idx_ok;
  logic [5:0]        off;
  logic [SYNC_W-1:0] raw_pins, sync_pins;
  logic [7:0]        rd_arr [NS];
  logic [NS-1:0]     pend;
  logic [4*NS-1:0]   irq_num;
  logic [7:0]        rd_mux;

  assign sel    = reg_idx[7:6];
  assign off    = reg_idx[5:0];
  assign idx_ok = (int'(reg_idx[7]) < NUM_CTRL);

  for (genvar s = 0; s < NS; s++) begin : g_pack
    assign raw_pins[PIN_W*s +: PIN_W] = {pgood_i[s], ready_i[s], wprot_i[s],
                                         det_b_i[s], det_a_i[s], batt_b_i[s], batt_a_i[s]};
  end

  pin_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_pins), .dout(sync_pins)
  );

  for (genvar s = 0; s < NS; s++) begin : g_sock
    logic hit;
    assign hit = idx_ok && (sel == 2'(s));
    sock_regs #(.ID_CODE(ID_CODE)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .pins(pins_t'(sync_pins[PIN_W*s +: PIN_W])),
      .wr(reg_wr && hit), .rd(reg_rd && hit), .off(off), .wdata(reg_wdata),
      .rdata(rd_arr[s]),
      .pwr_en(pwr_en_o[s]), .out_en(out_en_o[s]), .vpp(vpp_sel_o[2*s +: 2]),
      .card_rst_n(card_rst_n_o[s]), .io_mode(io_mode_o[s]),
      .pend(pend[s]), .irq_num(irq_num[4*s +: 4])
    );

    assert_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend[s] |-> (irq_lines_o[irq_num[4*s +: 4]] && irq_any_o));
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int s = 0; s < NS; s++) begin
      if (idx_ok && sel == 2'(s)) rd_mux = rd_arr[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= 8'h00;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  irq_router #(.NS(NS)) u_route (
    .pend(pend), .num(irq_num), .lines(irq_lines_o), .any(irq_any_o)
  );

  assert_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && idx_ok && off == OFF_ID) |=> (reg_rdata == ID_CODE));
  assert_bad_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !idx_ok) |=> (reg_rdata == 8'h00));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sock_stat_unit_test.sv
module sock_stat_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam logic [7:0] OP_WR = 8'd1;
  localparam logic [7:0] OP_RD = 8'd2;
  localparam int NVEC = 26;

  // {requirement number, op, index, write data, expected read}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd1,  OP_RD, 8'h00, 8'h00, 8'h83},  // R1 id
    {8'd1,  OP_WR, 8'h00, 8'h55, 8'h00},  // R1 write ignored
    {8'd1,  OP_RD, 8'h00, 8'h00, 8'h83},
    {8'd10, OP_RD, 8'h02, 8'h00, 8'h00},  // R10 reset values
    {8'd10, OP_RD, 8'h03, 8'h00, 8'h00},
    {8'd10, OP_RD, 8'h05, 8'h00, 8'h00},
    {8'd3,  OP_WR, 8'h02, 8'hFF, 8'h00},  // R3 stored bits
    {8'd3,  OP_RD, 8'h02, 8'h00, 8'hB3},
    {8'd4,  OP_WR, 8'h03, 8'hEA, 8'h00},  // R4 bit 7 dropped
    {8'd4,  OP_RD, 8'h03, 8'h00, 8'h6A},
    {8'd7,  OP_WR, 8'h05, 8'hA3, 8'h00},  // R7 config r/w
    {8'd7,  OP_RD, 8'h05, 8'h00, 8'hA3},
    {8'd9,  OP_WR, 8'h06, 8'h5A, 8'h00},  // R9 window enable
    {8'd9,  OP_RD, 8'h06, 8'h00, 8'h5A},
    {8'd9,  OP_RD, 8'h07, 8'h00, 8'h00},  // R9 unused offsets
    {8'd9,  OP_RD, 8'h3F, 8'h00, 8'h00},
    {8'd8,  OP_WR, 8'h45, 8'h11, 8'h00},  // R8 socket 1 separate
    {8'd8,  OP_RD, 8'h45, 8'h00, 8'h11},
    {8'd8,  OP_RD, 8'h05, 8'h00, 8'hA3},
    {8'd8,  OP_WR, 8'h82, 8'hFF, 8'h00},  // R8 unmapped half
    {8'd8,  OP_RD, 8'h82, 8'h00, 8'h00},
    {8'd5,  OP_WR, 8'h04, 8'hFF, 8'h00},  // R5 write ignored
    {8'd5,  OP_RD, 8'h04, 8'h00, 8'h00},
    {8'd10, OP_WR, 8'h02, 8'h00, 8'h00},  // cleanup
    {8'd10, OP_WR, 8'h03, 8'h00, 8'h00},
    {8'd10, OP_WR, 8'h45, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_idx = '0, reg_wdata = '0, reg_rdata;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0] pin_s [NS];  // {pgood,ready,wprot,det_b,det_a,batt_b,batt_a}
  logic [NS-1:0] det_a, det_b, batt_a, batt_b, wprot, ready, pgood;
  logic [NS-1:0] pwr_en, out_en, card_rst_n, io_mode;
  logic [2*NS-1:0] vpp_sel;
  logic [15:0] irq_lines;
  logic irq_any;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      {pgood[s], ready[s], wprot[s], det_b[s], det_a[s], batt_b[s], batt_a[s]} = pin_s[s];
    end
  end

  sock_stat_unit #(.NUM_CTRL(1), .ID_CODE(8'h83)) uut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .det_a_i(det_a), .det_b_i(det_b), .batt_a_i(batt_a), .batt_b_i(batt_b),
    .wprot_i(wprot), .ready_i(ready), .pgood_i(pgood),
    .pwr_en_o(pwr_en), .out_en_o(out_en), .vpp_sel_o(vpp_sel),
    .card_rst_n_o(card_rst_n), .io_mode_o(io_mode),
    .irq_lines_o(irq_lines), .irq_any_o(irq_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input string req, input logic [7:0] idx, input logic [7:0] exp);
    @(negedge clk); reg_idx = idx; reg_rd = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_rd = 1'b0;
    check(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic set_pins(input int s, input logic [6:0] v);
    @(negedge clk); pin_s[s] = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    pin_s[0] = 7'b0; pin_s[1] = 7'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state of outputs
    check("R10 pwr_en", 32'(pwr_en), 0);
    check("R10 out_en", 32'(out_en), 0);
    check("R10 irq", 32'({irq_any, irq_lines}), 0);
    check("R4 reset holds card", 32'(card_rst_n), 0);
    check("R11 rdata reset", 32'(reg_rdata), 0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][31:24] == OP_WR) wr_reg(VEC[i][23:16], VEC[i][15:8]);
      else rd_reg($sformatf("R%0d vec%0d", VEC[i][39:32], i), VEC[i][23:16], VEC[i][7:0]);
    end
    // R11 data held without a read
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 hold", 32'(reg_rdata), 0);

    // R2 / R5 status and change latching
    set_pins(0, 7'b0000100);
    rd_reg("R2 status det_a", 8'h01, 8'h04);
    rd_reg("R5 half detect no event", 8'h04, 8'h00);
    set_pins(0, 7'b1011111);
    rd_reg("R2 status all", 8'h01, 8'h5F);
    rd_reg("R8 socket1 status", 8'h41, 8'h00);
    rd_reg("R5 presence change", 8'h04, 8'h08);
    rd_reg("R6 cleared", 8'h04, 8'h00);
    set_pins(0, 7'b1011101);
    rd_reg("R5 batt B fall", 8'h04, 8'h02);
    set_pins(0, 7'b1011100);
    rd_reg("R5 batt A fall", 8'h04, 8'h01);
    set_pins(0, 7'b1011111);
    rd_reg("R5 batt rise no event", 8'h04, 8'h00);

    // R3 power control outputs
    wr_reg(8'h02, 8'h90);
    check("R3 pwr_en", 32'(pwr_en[0]), 1);
    check("R3 out_en", 32'(out_en[0]), 1);
    check("R3 socket1 untouched", 32'(pwr_en[1]), 0);
    wr_reg(8'h02, 8'hB2);
    check("R3 auto present pwr", 32'(pwr_en[0]), 1);
    check("R3 vpp 12V", 32'(vpp_sel[1:0]), 2);
    set_pins(0, 7'b1010111);
    check("R3 auto absent pwr", 32'(pwr_en[0]), 0);
    check("R3 auto absent oe", 32'(out_en[0]), 0);
    rd_reg("R5 removal", 8'h04, 8'h08);
    set_pins(0, 7'b1011111);
    check("R3 auto back", 32'(pwr_en[0]), 1);
    rd_reg("R5 insertion", 8'h04, 8'h08);
    wr_reg(8'h02, 8'h00);
    check("R3 zero write pwr", 32'(pwr_en[0]), 0);
    check("R3 zero write oe", 32'(out_en[0]), 0);

    // R4 general control outputs
    wr_reg(8'h03, 8'h40);
    check("R4 release reset", 32'(card_rst_n[0]), 1);
    check("R4 memory mode", 32'(io_mode[0]), 0);
    wr_reg(8'h03, 8'h60);
    check("R4 io mode", 32'(io_mode[0]), 1);
    wr_reg(8'h03, 8'h00);
    check("R4 reset again", 32'(card_rst_n[0]), 0);

    // R7 interrupt routing
    wr_reg(8'h05, 8'h58);
    set_pins(0, 7'b1011011);
    check("R7 irq5 line", 32'(irq_lines), 32'h0020);
    check("R7 irq any", 32'(irq_any), 1);
    rd_reg("R7 chg", 8'h04, 8'h08);
    check("R7 irq cleared", 32'({irq_any, irq_lines}), 0);
    set_pins(0, 7'b1011010);
    check("R7 masked battery", 32'({irq_any, irq_lines}), 0);
    rd_reg("R7 masked chg", 8'h04, 8'h01);
    set_pins(0, 7'b1011111);
    rd_reg("R7 reinsert", 8'h04, 8'h08);
    wr_reg(8'h45, 8'h98);
    set_pins(1, 7'b0001100);
    check("R7 irq9 socket1", 32'(irq_lines), 32'h0200);
    rd_reg("R8 socket1 chg", 8'h44, 8'h08);
    check("R7 socket1 cleared", 32'(irq_any), 0);

    // R6 event on the clearing edge is kept
    set_pins(0, 7'b1011110);
    @(negedge clk); pin_s[0] = 7'b1011010;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); reg_idx = 8'h04; reg_rd = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_rd = 1'b0;
    check("R6 old bits returned", 32'(reg_rdata), 32'h01);
    rd_reg("R6 new edge kept", 8'h04, 8'h08);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule